// File: doc/BRIEF.md
# Switch Gate Pulse Sequencer

This block times the two power switches of one half of a vibration-driven electrostatic energy harvester. While idle it keeps both switch enables low. An external trigger, issued when the variable capacitor is near its largest value, starts one conversion. The block then steps through five fixed phases: an inductor charge, a transfer into the capacitor, a long hold while the plates separate, a transfer back into the inductor, and a return to the reservoir.

The component values are known in advance, so every phase width is a programmed constant and no current sensing is used. Each width comes from two parts. A coarse counter runs on the fast clock until it equals the phase's coarse setting. It then launches a pulse into a fine tapped chain, and a tap select decides where the pulse is picked off. The upper half of the chain only receives the pulse when the top bit of the tap select is set, so unused stages do not toggle.

Top module: `sw_pulse_sequencer`

## Requirements
- R1: After reset and while no conversion runs, `busy_o`, `sw1_en_o` and `sw2_en_o` are all low, and the block stays idle until `trig_i` is seen high on a clock edge.
- R2: A conversion runs its phases in this order, with these switch states: phase 1 has only SW2 on, phase 2 has only SW1 on, phase 3 has both off, phase 4 has only SW1 on, and phase 5 has only SW2 on. The first phase is visible in the cycle after the edge that samples the trigger.
- R3: Phase k (k = 1..5) lasts exactly C + F + 2 fast-clock cycles. C is the 16-bit field `coarse_cfg_i[(k-1)*16 +: 16]` and F is the 4-bit field `fine_cfg_i[(k-1)*4 +: 4]`.
- R4: SW1 and SW2 are never high in the same cycle. Between two consecutive phases there is exactly one cycle with both switches off and `busy_o` high.
- R5: A trigger that arrives while `busy_o` is high has no effect. `busy_o` stays high through the last cycle of phase 5 and is low in the cycle after it.
- R6: The configuration inputs are captured on the edge that starts a conversion. Changes to them during the conversion do not alter any phase width.
- R7: Fine settings 8 to 15 route the pulse through the upper half of the fine chain and still give the width of R3. While a phase with a fine setting below 8 runs, the upper half of the chain stays inactive.
- R8: If the trigger is high in the idle cycle that follows the end of phase 5, a new conversion starts right after that single idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Conversion start request |
| coarse_cfg_i | input | 80 | Five 16-bit coarse counts; phase 1 in the lowest field |
| fine_cfg_i | input | 20 | Five 4-bit tap selects; phase 1 in the lowest field |
| sw1_en_o | output | 1 | Gate enable for the switch that feeds the capacitor |
| sw2_en_o | output | 1 | Gate enable for the switch that ties the inductor to the reservoir |
| busy_o | output | 1 | High from the first cycle of phase 1 through the last cycle of phase 5 |

## Verification
The properties assume that `trig_i` and the configuration buses are synchronous to `clk`. They accept configuration changes at any time and only claim that the captured copy stays stable while a conversion runs. The stimulus drives every input on the falling edge and keeps coarse settings small, apart from one long hold phase, so that each run stays short. It also drives stray triggers and configuration changes in the middle of a conversion, and holds the trigger high across the end of a conversion, to cover the cases the properties allow.

// File: rtl/sps_pkg.sv
package sps_pkg;

    // Fixed conversion sequence: five phases
    localparam int unsigned NUM_PHASES = 5;
    localparam int unsigned PH_W       = $clog2(NUM_PHASES);
    localparam int unsigned MAP_W      = 1 << PH_W;

    // Per-phase switch maps, bit index = phase index (0 = phase 1)
    localparam logic [MAP_W-1:0] SW1_MAP = MAP_W'(5'b01010);
    localparam logic [MAP_W-1:0] SW2_MAP = MAP_W'(5'b10001);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } seq_st_e;

endpackage

// File: rtl/sps_coarse_counter.sv
module sps_coarse_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] ref_i,
    output logic             launch_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fired;
    } cc_t;

    cc_t cc_d, cc_q;

    always_comb begin
        cc_d     = cc_q;
        launch_o = 1'b0;
        if (!run_i) begin
            cc_d = '0;
        end else if (!cc_q.fired) begin
            if (cc_q.cnt == ref_i) begin
                launch_o   = 1'b1;
                cc_d.fired = 1'b1;
            end else begin
                cc_d.cnt = cc_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cc_q <= '0;
        else        cc_q <= cc_d;
    end

endmodule

// File: rtl/sps_fine_chain.sv
module sps_fine_chain #(
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             pulse_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tap_o,
    output logic             upper_act_o
);

    localparam int unsigned TAPS = 1 << SEL_W;
    localparam int unsigned HALF = TAPS / 2;

    logic [TAPS-1:0] stg_d, stg_q;

    // The stage at HALF is fed only when the select MSB asks for the upper half
    always_comb begin
        stg_d = '0;
        if (!clr_i) begin
            stg_d[0] = pulse_i;
            for (int k = 1; k < TAPS; k++) begin
                if (k == HALF) stg_d[k] = stg_q[k-1] & sel_i[SEL_W-1];
                else           stg_d[k] = stg_q[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign tap_o       = stg_q[sel_i];
    assign upper_act_o = |stg_q[TAPS-1:HALF];

endmodule

// File: rtl/sw_pulse_sequencer.sv
module sw_pulse_sequencer
    import sps_pkg::*;
#(
    parameter int unsigned CRS_W = 16,
    parameter int unsigned FIN_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        trig_i,
    input  logic [NUM_PHASES*CRS_W-1:0] coarse_cfg_i,
    input  logic [NUM_PHASES*FIN_W-1:0] fine_cfg_i,
    output logic                        sw1_en_o,
    output logic                        sw2_en_o,
    output logic                        busy_o
);

    localparam int unsigned CFG_W = NUM_PHASES * (CRS_W + FIN_W);

    typedef struct packed {
        seq_st_e                     st;
        logic [PH_W-1:0]             ph;
        logic [NUM_PHASES*CRS_W-1:0] crs;
        logic [NUM_PHASES*FIN_W-1:0] fin;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             run;
    logic             launch;
    logic             done;
    logic             upper_act;
    logic             sel_msb;
    logic [CRS_W-1:0] cur_crs;
    logic [FIN_W-1:0] cur_fin;
    logic [CFG_W-1:0] cfg_held;

    assign run      = (seq_q.st == ST_RUN);
    assign cur_crs  = seq_q.crs[seq_q.ph*CRS_W +: CRS_W];
    assign cur_fin  = seq_q.fin[seq_q.ph*FIN_W +: FIN_W];
    assign sel_msb  = cur_fin[FIN_W-1];
    assign cfg_held = {seq_q.crs, seq_q.fin};

    sps_coarse_counter #(
        .CNT_W (CRS_W)
    ) i_coarse (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .ref_i    (cur_crs),
        .launch_o (launch)
    );

    sps_fine_chain #(
        .SEL_W (FIN_W)
    ) i_fine (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (!run),
        .pulse_i     (launch),
        .sel_i       (cur_fin),
        .tap_o       (done),
        .upper_act_o (upper_act)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (trig_i) begin
                    seq_d.st  = ST_RUN;
                    seq_d.ph  = '0;
                    seq_d.crs = coarse_cfg_i;
                    seq_d.fin = fine_cfg_i;
                end
            end
            ST_RUN: begin
                if (done) begin
                    if (seq_q.ph == PH_W'(NUM_PHASES - 1)) begin
                        seq_d.st = ST_IDLE;
                    end else begin
                        seq_d.st = ST_GAP;
                        seq_d.ph = seq_q.ph + 1'b1;
                    end
                end
            end
            ST_GAP:  seq_d.st = ST_RUN;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign sw1_en_o = run & SW1_MAP[seq_q.ph];
    assign sw2_en_o = run & SW2_MAP[seq_q.ph];
    assign busy_o   = (seq_q.st != ST_IDLE);

endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
    parameter int unsigned CFG_W = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw1_en_o,
    input logic             sw2_en_o,
    input logic             busy_o,
    input logic             run,
    input logic             sel_msb,
    input logic             upper_act,
    input logic [CFG_W-1:0] cfg_held
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sw1_en_o && !sw2_en_o));

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw1_en_o && sw2_en_o));

    // R4
    sw1_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw1_en_o) |-> !$past(sw2_en_o));

    // R4
    sw2_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw2_en_o) |-> !$past(sw1_en_o));

    // R2
    first_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (sw2_en_o && !sw1_en_o));

    // R5
    end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(sw2_en_o));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(cfg_held));

    // R7
    upper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sel_msb) |-> !upper_act);

endmodule

bind sw_pulse_sequencer sps_checker #(
    .CFG_W (NUM_PHASES * (CRS_W + FIN_W))
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw1_en_o  (sw1_en_o),
    .sw2_en_o  (sw2_en_o),
    .busy_o    (busy_o),
    .run       (run),
    .sel_msb   (sel_msb),
    .upper_act (upper_act),
    .cfg_held  (cfg_held)
);

// File: tb/test_sw_pulse_sequencer.sv
module test_sw_pulse_sequencer;

    localparam int unsigned NP  = 5;
    localparam int unsigned CW  = 16;
    localparam int unsigned FWI = 4;

    logic              clk   = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig  = 1'b0;
    logic [NP*CW-1:0]  crs   = '0;
    logic [NP*FWI-1:0] fin   = '0;
    logic              sw1;
    logic              sw2;
    logic              busy;

    int    checks   = 0;
    int    errors   = 0;
    string tag      = "R1";
    bit    mon_on   = 1'b0;
    bit    finished = 1'b0;

    // expected {busy, sw1, sw2} per cycle
    logic [2:0] exp_q[$];

    always #4 clk = ~clk;

    sw_pulse_sequencer i_sw_pulse_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig),
        .coarse_cfg_i (crs),
        .fine_cfg_i   (fin),
        .sw1_en_o     (sw1),
        .sw2_en_o     (sw2),
        .busy_o       (busy)
    );

    task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual {busy,sw1,sw2}=%b expected %b", req, $time, got, exp);
        end
    endtask

    // Monitor: compare every cycle, 2 ns after the rising edge
    initial begin
        logic [2:0] e;
        forever begin
            @(posedge clk);
            #2;
            if (mon_on) begin
                if (exp_q.size() != 0) e = exp_q.pop_front();
                else                   e = 3'b000;
                chk(tag, {busy, sw1, sw2}, e);
            end
        end
    end

    // Driver side: expected stream from the requirements
    task automatic push_seq(input int c[NP], input int f[NP]);
        for (int k = 0; k < NP; k++) begin
            logic s1;
            logic s2;
            s1 = (k == 1) || (k == 3);
            s2 = (k == 0) || (k == 4);
            for (int n = 0; n < c[k] + f[k] + 2; n++) exp_q.push_back({1'b1, s1, s2});
            if (k < NP - 1) exp_q.push_back(3'b100);
        end
    endtask

    task automatic load(input int c[NP], input int f[NP]);
        for (int k = 0; k < NP; k++) begin
            crs[k*CW +: CW]   = CW'(c[k]);
            fin[k*FWI +: FWI] = FWI'(f[k]);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_seq(input string req, input int c[NP], input int f[NP]);
        @(negedge clk);
        tag = req;
        load(c, f);
        trig = 1'b1;
        push_seq(c, f);
        @(negedge clk);
        trig = 1'b0;
        drain();
    endtask

    initial begin
        int seq_len;
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R1", {busy, sw1, sw2}, 3'b000);
        @(negedge clk);
        rst_n  = 1'b1;
        mon_on = 1'b1;
        tag    = "R1";
        repeat (10) @(negedge clk);

        // R2 / R3 / R4: basic sequence with distinct widths
        run_seq("R2", '{3, 5, 20, 4, 6}, '{0, 1, 2, 3, 4});
        // R3: zero coarse and zero fine give the minimum width
        run_seq("R3", '{0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0});
        // R3: long hold phase
        run_seq("R3", '{1, 2, 2000, 3, 0}, '{5, 0, 15, 8, 2});
        // R7: taps in the upper half, plus the boundary taps 0 and 7
        run_seq("R7", '{0, 1, 0, 2, 0}, '{8, 15, 0, 7, 12});
        // R4: dead cycles with different widths around each handover
        run_seq("R4", '{7, 0, 3, 0, 9}, '{1, 14, 0, 6, 3});

        // R5 / R6: stray trigger and configuration changes mid-conversion
        @(negedge clk);
        tag = "R5";
        load('{4, 6, 30, 5, 2}, '{2, 3, 1, 9, 0});
        trig = 1'b1;
        push_seq('{4, 6, 30, 5, 2}, '{2, 3, 1, 9, 0});
        @(negedge clk);
        trig = 1'b0;
        repeat (6) @(negedge clk);
        tag  = "R6";
        trig = 1'b1;
        load('{50, 50, 50, 50, 50}, '{15, 15, 15, 15, 15});
        @(negedge clk);
        trig = 1'b0;
        repeat (20) @(negedge clk);
        load('{0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0});
        drain();

        // R8: trigger held across the end of a conversion
        @(negedge clk);
        tag = "R8";
        load('{2, 1, 5, 1, 3}, '{1, 0, 2, 4, 0});
        trig = 1'b1;
        push_seq('{2, 1, 5, 1, 3}, '{1, 0, 2, 4, 0});
        seq_len = exp_q.size();
        exp_q.push_back(3'b000);
        push_seq('{2, 1, 5, 1, 3}, '{1, 0, 2, 4, 0});
        while (exp_q.size() >= seq_len) @(negedge clk);
        trig = 1'b0;
        drain();

        // R1: stays idle with no trigger
        tag = "R1";
        repeat (10) @(negedge clk);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual still running, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule